// File: doc/BRIEF.md
# Paged Register Management Bridge

This block lets a host reach a 32-bit register space that sits behind a 16-bit management bus. Each host access carries a byte address, a read/write flag and, for writes, a 32-bit word. The bridge turns it into three management transactions, all aimed at one device address. The first selects a page. The second moves the low half of the word through a register inside that page. The third moves the high half through a fixed register.

On the host side, a request is taken when `host_req_valid` and `host_req_ready` are both high. Completion is reported by a one-cycle `host_rsp_done` pulse, which carries the read word and an error flag. On the downstream side there is a plain command port. A command is held until the far side pulses `mc_done`, and the far side may flag an error with that pulse. The device address lives in a small configuration register. It comes out of reset at a parameter value (31 by default), and a write strobe can change it.

Top module: `paged_mgmt_bridge`

## Requirements
- R1: After reset, `host_req_ready` is 1, `mc_valid` is 0 and `host_rsp_done` is 0, and the device address equals the parameter default (31).
- R2: The first command of every access is a write to management register 0x1F. Its data is the page, taken from address bits [15:6] and zero-extended to 16 bits.
- R3: The second command addresses management register number address[5:2], zero-extended to 5 bits. Address bits [1:0] have no effect on any command.
- R4: A write issues exactly three write commands in this order: the page to 0x1F, data[15:0] to the in-page register, then data[31:16] to register 0x10.
- R5: A read issues a page write to 0x1F, then a read of the in-page register, then a read of register 0x10. It returns {second read value, first read value} on `host_rsp_rdata`.
- R6: Every command of an access carries the device address on `mc_phy`. A pulse on `cfg_dev_we` loads `cfg_dev_addr` as the device address for later accesses.
- R7: The device address is captured when a request is accepted. A configuration write during a sequence does not change `mc_phy` for the rest of that access.
- R8: If any command completes with `mc_err` = 1, no further command of that access is issued, and the access completes with `host_rsp_err` = 1.
- R9: From the cycle after acceptance until the response cycle, `host_req_ready` is 0, and no request is taken even if `host_req_valid` stays high.
- R10: `host_rsp_done` is a single-cycle pulse in the cycle after the final `mc_done`. In that cycle `host_rsp_err` and `host_rsp_rdata` are valid. `host_rsp_rdata` is 0 for writes and for accesses that end in error.
- R11: While `mc_valid` is 1 and `mc_done` has not arrived, `mc_phy`, `mc_reg`, `mc_write` and `mc_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dev_we | input | 1 | Load strobe for the device address |
| cfg_dev_addr | input | 5 | New device address |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Bridge idle and able to take a request |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_addr | input | 16 | Byte address of the 32-bit register |
| host_req_wdata | input | 32 | Write word |
| host_rsp_done | output | 1 | One-cycle completion pulse |
| host_rsp_rdata | output | 32 | Read word, valid with done |
| host_rsp_err | output | 1 | Access failed, valid with done |
| mc_valid | output | 1 | Management command pending |
| mc_phy | output | 5 | Device address of the command |
| mc_reg | output | 5 | Management register number |
| mc_write | output | 1 | 1 = write command, 0 = read command |
| mc_wdata | output | 16 | Write data of the command |
| mc_done | input | 1 | Command finished (pulse) |
| mc_err | input | 1 | Command failed, valid with done |
| mc_rdata | input | 16 | Read result, valid with done |

## Verification
The hardest cases to reach are an error on the middle or last step, and events that land while a sequence is in flight: a configuration write, or a host that keeps requesting. The bench's downstream responder counts steps within each access and can fail any chosen step. It also draws a random latency for every command, so a configuration pulse or a held request can be placed a set number of cycles after acceptance. The bench then checks that the expected command queue drains exactly, with no extra command and no changed device address.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
  // Width of a management register number
  localparam int unsigned MGMT_REG_W = 5;
  // Register that selects the page on the far device
  localparam logic [MGMT_REG_W-1:0] PAGE_SEL_REG = 5'h1F;
  // Register that carries the upper half of every word
  localparam logic [MGMT_REG_W-1:0] HIGH_HALF_REG = 5'h10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PAGE = 2'd1,
    ST_LOW  = 2'd2,
    ST_HIGH = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pgb_addr_split.sv
module pgb_addr_split #(
  parameter int unsigned PAGE_W = 10,
  parameter int unsigned IDX_W  = 4,
  localparam int unsigned IDX_LSB  = 2,
  localparam int unsigned PAGE_LSB = IDX_LSB + IDX_W,
  localparam int unsigned ADDR_W   = PAGE_LSB + PAGE_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PAGE_W-1:0] page,
  output logic [IDX_W-1:0]  idx
);
  // The byte lane bits select nothing: registers sit on a 4-byte stride
  logic unused_lane;

  assign page        = addr[PAGE_LSB +: PAGE_W];
  assign idx         = addr[IDX_LSB +: IDX_W];
  assign unused_lane = ^addr[IDX_LSB-1:0];
endmodule

// File: rtl/pgb_dev_cfg.sv
module pgb_dev_cfg #(
  parameter int unsigned  PHY_W   = 5,
  parameter logic [4:0]   DEF_DEV = 5'd31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [PHY_W-1:0] cfg_val,
  input  logic             accept,
  input  logic             busy,
  output logic [PHY_W-1:0] dev_lat
);
  logic [PHY_W-1:0] cfg_q, cfg_d;
  logic [PHY_W-1:0] lat_q, lat_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) cfg_d = cfg_val;
  end

  always_comb begin
    lat_d = lat_q;
    if (accept) lat_d = cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= PHY_W'(DEF_DEV);
      lat_q <= PHY_W'(DEF_DEV);
    end else begin
      cfg_q <= cfg_d;
      lat_q <= lat_d;
    end
  end

  assign dev_lat = lat_q;

  // R7
  dev_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> $stable(dev_lat));
endmodule

// File: rtl/pgb_seq.sv
module pgb_seq
  import pgb_pkg::*;
#(
  parameter int unsigned PAGE_W = 10,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned HALF_W = 16,
  localparam int unsigned WORD_W = 2 * HALF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [PAGE_W-1:0]     req_page,
  input  logic [IDX_W-1:0]      req_idx,
  input  logic [WORD_W-1:0]     req_wdata,
  output logic                  req_ready,
  output logic                  accept,
  output logic                  busy,
  output logic                  rsp_done,
  output logic [WORD_W-1:0]     rsp_rdata,
  output logic                  rsp_err,
  output logic                  mc_valid,
  output logic [MGMT_REG_W-1:0] mc_reg,
  output logic                  mc_write,
  output logic [HALF_W-1:0]     mc_wdata,
  input  logic                  mc_done,
  input  logic                  mc_err,
  input  logic [HALF_W-1:0]     mc_rdata
);
  seq_state_e        state_q, state_d;
  logic              wr_q;
  logic [PAGE_W-1:0] page_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] wdata_q;
  logic [HALF_W-1:0] low_q, low_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              step_done, finish, low_en;

  assign busy      = (state_q != ST_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign step_done = busy && mc_done;
  assign finish    = step_done && (mc_err || state_q == ST_HIGH);
  assign low_en    = step_done && !mc_err && (state_q == ST_LOW);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_PAGE;
      ST_PAGE: if (step_done) state_d = mc_err ? ST_IDLE : ST_LOW;
      ST_LOW:  if (step_done) state_d = mc_err ? ST_IDLE : ST_HIGH;
      ST_HIGH: if (step_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    low_d = low_q;
    if (low_en) low_d = mc_rdata;
  end

  always_comb begin
    done_d  = finish;
    err_d   = finish && mc_err;
    rdata_d = '0;
    if (finish && !mc_err && !wr_q) rdata_d = {mc_rdata, low_q};
  end

  // State and response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      low_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      low_q   <= low_d;
      done_q  <= done_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  // Request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      page_q  <= '0;
      idx_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      page_q  <= req_page;
      idx_q   <= req_idx;
      wdata_q <= req_wdata;
    end
  end

  // Command decode
  always_comb begin
    mc_valid = busy;
    mc_write = wr_q;
    mc_reg   = '0;
    mc_wdata = '0;
    unique case (state_q)
      ST_PAGE: begin
        mc_write = 1'b1;
        mc_reg   = PAGE_SEL_REG;
        mc_wdata = HALF_W'(page_q);
      end
      ST_LOW: begin
        mc_reg = MGMT_REG_W'(idx_q);
        if (wr_q) mc_wdata = wdata_q[HALF_W-1:0];
      end
      ST_HIGH: begin
        mc_reg = HIGH_HALF_REG;
        if (wr_q) mc_wdata = wdata_q[WORD_W-1:HALF_W];
      end
      default: ;
    endcase
  end

  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R2
  page_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (mc_valid && mc_write && mc_reg == PAGE_SEL_REG));
  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_valid && !mc_done) |=> (mc_valid && $stable(mc_reg) && $stable(mc_wdata) && $stable(mc_write)));
  // R8
  stop_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_valid && mc_done && mc_err) |=> (!mc_valid && rsp_done && rsp_err));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

// File: rtl/paged_mgmt_bridge.sv
module paged_mgmt_bridge #(
  parameter int unsigned PAGE_W  = 10,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned HALF_W  = 16,
  parameter int unsigned PHY_W   = 5,
  parameter logic [4:0]  DEF_DEV = 5'd31,
  localparam int unsigned ADDR_W = PAGE_W + IDX_W + 2,
  localparam int unsigned WORD_W = 2 * HALF_W,
  localparam int unsigned REG_W  = pgb_pkg::MGMT_REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dev_we,
  input  logic [PHY_W-1:0]  cfg_dev_addr,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic [ADDR_W-1:0] host_req_addr,
  input  logic [WORD_W-1:0] host_req_wdata,
  output logic              host_rsp_done,
  output logic [WORD_W-1:0] host_rsp_rdata,
  output logic              host_rsp_err,
  output logic              mc_valid,
  output logic [PHY_W-1:0]  mc_phy,
  output logic [REG_W-1:0]  mc_reg,
  output logic              mc_write,
  output logic [HALF_W-1:0] mc_wdata,
  input  logic              mc_done,
  input  logic              mc_err,
  input  logic [HALF_W-1:0] mc_rdata
);
  logic [PAGE_W-1:0] page;
  logic [IDX_W-1:0]  idx;
  logic              accept;
  logic              busy;

  pgb_addr_split #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_split (
    .addr (host_req_addr),
    .page (page),
    .idx  (idx)
  );

  pgb_dev_cfg #(.PHY_W(PHY_W), .DEF_DEV(DEF_DEV)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_dev_we),
    .cfg_val (cfg_dev_addr),
    .accept  (accept),
    .busy    (busy),
    .dev_lat (mc_phy)
  );

  pgb_seq #(.PAGE_W(PAGE_W), .IDX_W(IDX_W), .HALF_W(HALF_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (host_req_valid),
    .req_write (host_req_write),
    .req_page  (page),
    .req_idx   (idx),
    .req_wdata (host_req_wdata),
    .req_ready (host_req_ready),
    .accept    (accept),
    .busy      (busy),
    .rsp_done  (host_rsp_done),
    .rsp_rdata (host_rsp_rdata),
    .rsp_err   (host_rsp_err),
    .mc_valid  (mc_valid),
    .mc_reg    (mc_reg),
    .mc_write  (mc_write),
    .mc_wdata  (mc_wdata),
    .mc_done   (mc_done),
    .mc_err    (mc_err),
    .mc_rdata  (mc_rdata)
  );

  // R6
  phy_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_valid && $past(mc_valid) && !$past(host_rsp_done)) |-> $stable(mc_phy));
endmodule

// File: tb/test_paged_mgmt_bridge.sv
module test_paged_mgmt_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_dev_we;
  logic [4:0]  cfg_dev_addr;
  logic        host_req_valid, host_req_write;
  logic        host_req_ready;
  logic [15:0] host_req_addr;
  logic [31:0] host_req_wdata;
  logic        host_rsp_done, host_rsp_err;
  logic [31:0] host_rsp_rdata;
  logic        mc_valid, mc_write, mc_done, mc_err;
  logic [4:0]  mc_phy, mc_reg;
  logic [15:0] mc_wdata, mc_rdata;

  int checks = 0;
  int errors = 0;
  // expected command: {write, phy, reg, data}
  logic [26:0] expq[$];
  logic [9:0]  page_mem [32];
  int          resp_step;
  int          resp_err_at;
  logic [4:0]  dev_model;

  paged_mgmt_bridge i_paged_mgmt_bridge (.*);

  initial forever #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] dev_val(input logic [4:0] phy,
                                          input logic [9:0] pg, input logic [4:0] r);
    return {pg, r, 1'b0} ^ {phy, 11'h0};
  endfunction

  // Downstream responder and command checker
  initial begin
    bit         pending = 0;
    int         lat = 0;
    logic [26:0] snap = '0;
    mc_done = 0; mc_err = 0; mc_rdata = '0;
    forever begin
      @(negedge clk);
      mc_done = 0; mc_err = 0;
      if (rst_n && mc_valid) begin
        if (!pending) begin
          pending = 1;
          lat  = $urandom_range(0, 3);
          snap = {mc_write, mc_phy, mc_reg, mc_wdata};
        end else begin
          chk({mc_write, mc_phy, mc_reg, mc_wdata} == snap, "R11", "command held",
              32'({mc_write, mc_phy, mc_reg, mc_wdata}), 32'(snap));
        end
        if (lat == 0) begin
          logic [26:0] e;
          pending = 0;
          resp_step++;
          if (expq.size() == 0) begin
            chk(0, "R8", "unexpected command", 32'(snap), 0);
          end else begin
            e = expq.pop_front();
            chk(snap[26] == e[26] && snap[25:21] == e[25:21] && snap[20:16] == e[20:16] &&
                (!e[26] || snap[15:0] == e[15:0]), "R4/R5/R6", "command",
                32'(snap), 32'(e));
          end
          if (snap[26] && snap[20:16] == 5'h1F) page_mem[snap[25:21]] = snap[9:0];
          mc_rdata = dev_val(snap[25:21], page_mem[snap[25:21]], snap[20:16]);
          mc_done  = 1;
          mc_err   = (resp_step == resp_err_at);
        end else lat--;
      end
    end
  end

  task automatic access(input bit wr, input logic [15:0] a, input logic [31:0] wd,
                        input int err_at, input bit hold, input bit cfg_mid,
                        input logic [4:0] cfg_new, input string req);
    logic [4:0]  phy = dev_model;
    logic [9:0]  pg  = a[15:6];
    logic [4:0]  ix  = {1'b0, a[5:2]};
    int          n   = (err_at == 0) ? 3 : err_at;
    logic [26:0] all3 [3];
    logic [31:0] exp_rd;
    int          cyc = 0;
    all3[0] = {1'b1, phy, 5'h1F, 6'b0, pg};
    all3[1] = {wr, phy, ix, wr ? wd[15:0] : 16'h0};
    all3[2] = {wr, phy, 5'h10, wr ? wd[31:16] : 16'h0};
    for (int k = 0; k < n; k++) expq.push_back(all3[k]);
    exp_rd = (wr || err_at != 0) ? 32'h0 : {dev_val(phy, pg, 5'h10), dev_val(phy, pg, ix)};
    @(negedge clk);
    resp_step = 0; resp_err_at = err_at;
    chk(host_req_ready == 1, "R9", "ready when idle", 32'(host_req_ready), 1);
    host_req_valid = 1; host_req_write = wr; host_req_addr = a; host_req_wdata = wd;
    @(negedge clk);
    if (hold) begin host_req_addr = ~a; host_req_write = ~wr; end
    else host_req_valid = 0;
    forever begin
      if (host_rsp_done) break;
      chk(host_req_ready == 0, {req, " R9"}, "ready low while busy", 32'(host_req_ready), 0);
      cfg_dev_we = 0;
      if (cfg_mid && cyc == 1) begin
        cfg_dev_we = 1; cfg_dev_addr = cfg_new; dev_model = cfg_new;
      end
      @(negedge clk);
      cyc++;
    end
    host_req_valid = 0; cfg_dev_we = 0;
    chk(host_req_ready == 1, "R10", "ready with done", 32'(host_req_ready), 1);
    chk(host_rsp_err == (err_at != 0), {req, " R8"}, "error flag", 32'(host_rsp_err), 32'(err_at != 0));
    chk(host_rsp_rdata == exp_rd, {req, " R10"}, "read word", host_rsp_rdata, exp_rd);
    chk(expq.size() == 0, {req, " R8"}, "commands left", 32'(expq.size()), 0);
    expq.delete();
    @(negedge clk);
    chk(host_rsp_done == 0, "R10", "done is one cycle", 32'(host_rsp_done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_dev_we = 0; cfg_dev_addr = '0;
    host_req_valid = 0; host_req_write = 0; host_req_addr = '0; host_req_wdata = '0;
    dev_model = 5'd31; resp_step = 0; resp_err_at = 0;
    foreach (page_mem[i]) page_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(host_req_ready == 1, "R1", "ready in reset", 32'(host_req_ready), 1);
    chk(mc_valid == 0, "R1", "no command in reset", 32'(mc_valid), 0);
    chk(host_rsp_done == 0, "R1", "no done in reset", 32'(host_rsp_done), 0);
    rst_n = 1;
    @(negedge clk);
    // R1 R2 R4 R6: write with the default device address 31
    access(1, 16'h1234, 32'hDEADBEEF, 0, 0, 0, 0, "R1 R2 R4 R6");
    // R3 R5: top page and index, low address bits set
    access(0, 16'hFFFF, 0, 0, 0, 0, 0, "R3 R5");
    access(0, 16'h0040, 0, 0, 0, 0, 0, "R5");
    // R6: new device address
    @(negedge clk); cfg_dev_we = 1; cfg_dev_addr = 5'd7; dev_model = 5'd7;
    @(negedge clk); cfg_dev_we = 0;
    access(1, 16'h0ABC, 32'h01234567, 0, 0, 0, 0, "R6");
    access(0, 16'h0ABC, 0, 0, 0, 0, 0, "R6");
    // R7: configuration write during a read
    access(0, 16'h2468, 0, 0, 0, 1, 5'd12, "R7");
    access(1, 16'h0004, 32'hCAFEF00D, 0, 0, 0, 0, "R7");
    // R8: error on each step
    access(1, 16'h0100, 32'h11112222, 1, 0, 0, 0, "R8");
    access(1, 16'h0100, 32'h33334444, 2, 0, 0, 0, "R8");
    access(1, 16'h0100, 32'h55556666, 3, 0, 0, 0, "R8");
    access(0, 16'h0180, 0, 2, 0, 0, 0, "R8");
    // R9: host keeps requesting during a sequence
    access(1, 16'h3C3C, 32'hA5A55A5A, 0, 1, 0, 0, "R9");
    access(0, 16'h3C3C, 0, 0, 1, 0, 0, "R9");
    // mixed traffic
    for (int i = 0; i < 40; i++) begin
      int ea = ($urandom_range(0, 4) == 0) ? $urandom_range(1, 3) : 0;
      access($urandom_range(0, 1), 16'($urandom), $urandom, ea, 0, 0, 0, "R4 R5");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule